// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block decides, pin by pin, whether a general-purpose input port should raise an interrupt. It watches a 16-pin port. Each pin that is configured as an enabled input is first synchronized to the clock. Its new level is then compared with the level the unit last recorded for that pin. Per-pin configuration vectors decide how the pin is judged. A pin can be judged on its level or on an edge, and edge mode can select one edge or both. One polarity vector covers both modes. In level mode a polarity bit of 0 means active-high. In edge mode a polarity bit of 0 means a rising edge.

The per-pin interrupt states are gated by two independent mask vectors. The result drives two registered request lines, A and B, so one set of pin events can be routed to two interrupt controller inputs. The register interface that writes the configuration and masks lies outside this block, and so does the interrupt controller. The masks and configuration arrive as plain input vectors.

Top module: `gpio_irq_sense`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `irq_a_o` and `irq_b_o` are 0, every pin interrupt state is 0 and every recorded pin level is 0.
- R2: A pin takes part only when its `dir_cfg` bit is 0 (input) and its `inen_cfg` bit is 1. While a pin does not take part, changes on its input have no effect on either output. A level-mode pin keeps whatever interrupt state it had.
- R3: In level mode (`edge_cfg` bit 0) with `polar_cfg` bit 0, the pin's interrupt state is 1 while its synchronized level is 1. The state returns to 0 once the level is 0.
- R4: In level mode with `polar_cfg` bit 1, the pin's interrupt state is 1 while its synchronized level is 0. The state returns to 0 once the level is 1.
- R5: In edge mode (`edge_cfg` bit 1) with `both_cfg` bit 1, every change of the synchronized level produces an event, whichever its direction.
- R6: In edge mode with `both_cfg` bit 0 and `polar_cfg` bit 0, only a 0-to-1 change produces an event.
- R7: In edge mode with `both_cfg` bit 0 and `polar_cfg` bit 1, only a 1-to-0 change produces an event.
- R8: An edge event sets the pin's interrupt state for exactly one clock cycle. It is not held, so the request line it reaches is high for one cycle.
- R9: `irq_a_o` is the registered OR of (pin interrupt states AND `mask_a`). `irq_b_o` is the registered OR of (pin interrupt states AND `mask_b`).
- R10: A change of `mask_a` or `mask_b` is reflected on the matching output at the next rising edge.
- R11: A pin input change reaches the outputs at the fourth rising edge after it is applied: two synchronizer stages, the interrupt state register, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | PINS | Asynchronous pin levels |
| dir_cfg | input | PINS | 1 = pin is an output, so it is excluded |
| inen_cfg | input | PINS | 1 = input sensing enabled |
| polar_cfg | input | PINS | Level mode: 1 = active-low. Edge mode: 1 = falling edge |
| edge_cfg | input | PINS | 1 = edge mode, 0 = level mode |
| both_cfg | input | PINS | Edge mode: 1 = both edges |
| mask_a | input | PINS | Enable of each pin onto request A |
| mask_b | input | PINS | Enable of each pin onto request B |
| irq_a_o | output | 1 | Registered interrupt request A |
| irq_b_o | output | 1 | Registered interrupt request B |

## Verification
A one-cycle edge event and a mask change can meet in the same cycle. This is the case where a lost or stretched pulse would go unnoticed. The bench raises a rising-edge pin while its mask bit is still clear. It sets the mask bit in the very cycle the pin's interrupt state holds the pulse. It then requires the request line to go high for exactly that one cycle and to drop on the next. A second overlap is between the participation gate and a held level state. The bench disables a pin's input while its level interrupt is active and changes the pin. It then checks that the request stays high until the input is enabled again.

// File: rtl/gpio_irq_sense_pkg.sv
// Shared decision logic for the GPIO interrupt sense unit.
// Assumes levels are already synchronized to the clock.
package gpio_irq_sense_pkg;

    // Next interrupt state of one pin from its mode, old and new level.
    function automatic logic next_irq_state(
        input logic part,
        input logic edge_mode,
        input logic both,
        input logic polar,
        input logic old_lvl,
        input logic new_lvl,
        input logic cur
    );
        logic res;
        if (!part)
            res = edge_mode ? 1'b0 : cur;
        else if (!edge_mode)
            res = (new_lvl != polar);
        else if (both)
            res = (old_lvl != new_lvl);
        else if (polar)
            res = old_lvl & ~new_lvl;
        else
            res = ~old_lvl & new_lvl;
        return res;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-stage synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is needed.
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_sense.sv
// Interrupt condition of a single pin: records the pin level and
// derives the level or one-cycle edge state from the configuration.
// Assumes new_lvl is synchronous to clk.
module gpio_pin_sense
    import gpio_irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic part,
    input  logic edge_mode,
    input  logic both,
    input  logic polar,
    input  logic new_lvl,
    output logic level_q,
    output logic state_q
);
    // Recorded level follows the pin only while the pin takes part.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= 1'b0;
        else if (part)
            level_q <= new_lvl;
    end

    // Interrupt state: level condition, or one-cycle edge event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= 1'b0;
        else
            state_q <= next_irq_state(part, edge_mode, both, polar,
                                      level_q, new_lvl, state_q);
    end
endmodule

// File: rtl/gpio_irq_combine.sv
// Masks the per-pin interrupt states onto two registered request lines.
// Assumes masks may change in any cycle.
module gpio_irq_combine #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] state,
    input  logic [W-1:0] mask_a,
    input  logic [W-1:0] mask_b,
    output logic         irq_a,
    output logic         irq_b
);
    // Register the masked OR of each request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
        end else begin
            irq_a <= |(state & mask_a);
            irq_b <= |(state & mask_b);
        end
    end
endmodule

// File: rtl/gpio_irq_sense.sv
// GPIO interrupt sense unit: synchronizes pins, evaluates each enabled
// input pin in level or edge mode and drives two masked requests.
// Assumes configuration and masks are synchronous to clk.
module gpio_irq_sense #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] dir_cfg,
    input  logic [PINS-1:0] inen_cfg,
    input  logic [PINS-1:0] polar_cfg,
    input  logic [PINS-1:0] edge_cfg,
    input  logic [PINS-1:0] both_cfg,
    input  logic [PINS-1:0] mask_a,
    input  logic [PINS-1:0] mask_b,
    output logic            irq_a_o,
    output logic            irq_b_o
);
    logic [PINS-1:0] sync_lvl;
    logic [PINS-1:0] part;
    logic [PINS-1:0] level_q;
    logic [PINS-1:0] int_state;

    // A pin takes part only as an enabled input.
    assign part = ~dir_cfg & inen_cfg;

    gpio_pin_sync #(.W(PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_pin_sense sense_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .part      (part[p]),
            .edge_mode (edge_cfg[p]),
            .both      (both_cfg[p]),
            .polar     (polar_cfg[p]),
            .new_lvl   (sync_lvl[p]),
            .level_q   (level_q[p]),
            .state_q   (int_state[p])
        );
    end

    gpio_irq_combine #(.W(PINS)) comb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (int_state),
        .mask_a (mask_a),
        .mask_b (mask_b),
        .irq_a  (irq_a_o),
        .irq_b  (irq_b_o)
    );
endmodule

// File: rtl/gpio_irq_sense_chk.sv
// Property checker for gpio_irq_sense, attached by bind.
// Assumes synchronous active-low reset.
module gpio_irq_sense_chk #(
    parameter int PINS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PINS-1:0] part,
    input logic [PINS-1:0] polar_cfg,
    input logic [PINS-1:0] edge_cfg,
    input logic [PINS-1:0] mask_a,
    input logic [PINS-1:0] mask_b,
    input logic [PINS-1:0] sync_lvl,
    input logic [PINS-1:0] level_q,
    input logic [PINS-1:0] int_state,
    input logic            irq_a_o,
    input logic            irq_b_o
);
    // R2: level-mode pins that do not take part keep their state.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((int_state ^ $past(int_state)) & $past(~part & ~edge_cfg)) == '0));

    // R3 and R4: level state equals level differing from polarity.
    assert_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((int_state ^ $past(sync_lvl ^ polar_cfg)) & $past(part & ~edge_cfg)) == '0));

    // R5: no edge event when the level did not change.
    assert_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((int_state & $past(part & edge_cfg & ~(sync_lvl ^ level_q))) == '0));

    // R9: request A follows masked states one cycle later.
    assert_irqa_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_a_o == |($past(int_state & mask_a))));

    // R9: request B follows masked states one cycle later.
    assert_irqb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_b_o == |($past(int_state & mask_b))));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.PINS(PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .part      (part),
    .polar_cfg (polar_cfg),
    .edge_cfg  (edge_cfg),
    .mask_a    (mask_a),
    .mask_b    (mask_b),
    .sync_lvl  (sync_lvl),
    .level_q   (level_q),
    .int_state (int_state),
    .irq_a_o   (irq_a_o),
    .irq_b_o   (irq_b_o)
);

// File: tb/gpio_irq_sense_tb_top.sv
// Directed bench for gpio_irq_sense: one task per scenario.
module gpio_irq_sense_tb_top;
    localparam int PINS = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] dir_cfg = '0;
    logic [PINS-1:0] inen_cfg = '1;
    logic [PINS-1:0] polar_cfg = '0;
    logic [PINS-1:0] edge_cfg = '0;
    logic [PINS-1:0] both_cfg = '0;
    logic [PINS-1:0] mask_a = '0;
    logic [PINS-1:0] mask_b = '0;
    logic            irq_a_o;
    logic            irq_b_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_sense #(.PINS(PINS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .dir_cfg   (dir_cfg),
        .inen_cfg  (inen_cfg),
        .polar_cfg (polar_cfg),
        .edge_cfg  (edge_cfg),
        .both_cfg  (both_cfg),
        .mask_a    (mask_a),
        .mask_b    (mask_b),
        .irq_a_o   (irq_a_o),
        .irq_b_o   (irq_b_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count the cycles a request line is high over n cycles.
    task automatic count_high(input int n, input bit use_b, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (use_b ? irq_b_o : irq_a_o) hits++;
        end
    endtask

    task automatic t_reset();
        step(2);
        check("R1 irq_a after reset", irq_a_o, 0);
        check("R1 irq_b after reset", irq_b_o, 0);
    endtask

    task automatic t_level_high();
        mask_a = 16'h0001;
        pin_in[0] = 1'b1;
        step(3);
        check("R11 irq_a not before 4th edge", irq_a_o, 0);
        step(1);
        check("R3 level high raises irq_a", irq_a_o, 1);
        pin_in[0] = 1'b0;
        step(4);
        check("R3 level low clears irq_a", irq_a_o, 0);
        mask_a = '0;
    endtask

    task automatic t_level_low();
        polar_cfg[1] = 1'b1;
        mask_a = 16'h0002;
        step(2);
        check("R4 active-low pin at 0 raises irq_a", irq_a_o, 1);
        pin_in[1] = 1'b1;
        step(4);
        check("R4 active-low pin at 1 clears irq_a", irq_a_o, 0);
        pin_in[1] = 1'b0;
        step(4);
        check("R4 active-low pin back to 0", irq_a_o, 1);
        mask_a = '0;
        polar_cfg[1] = 1'b0;
        step(2);
    endtask

    task automatic t_ignore();
        mask_a = 16'h0004;
        dir_cfg[2] = 1'b1;
        pin_in[2] = 1'b1;
        step(5);
        check("R2 output pin ignored", irq_a_o, 0);
        dir_cfg[2] = 1'b0;
        inen_cfg[2] = 1'b0;
        step(5);
        check("R2 input-disabled pin ignored", irq_a_o, 0);
        inen_cfg[2] = 1'b1;
        step(2);
        check("R2 enabled pin raises irq_a", irq_a_o, 1);
        inen_cfg[2] = 1'b0;
        pin_in[2] = 1'b0;
        step(5);
        check("R2 disabled pin holds level state", irq_a_o, 1);
        inen_cfg[2] = 1'b1;
        step(2);
        check("R2 re-enabled pin clears", irq_a_o, 0);
        mask_a = '0;
    endtask

    task automatic t_rise();
        int hits;
        edge_cfg[3] = 1'b1;
        mask_b = 16'h0008;
        step(1);
        pin_in[3] = 1'b1;
        step(3);
        check("R11 edge not before 4th edge", irq_b_o, 0);
        step(1);
        check("R6 rising edge raises irq_b", irq_b_o, 1);
        step(1);
        check("R8 edge pulse is one cycle", irq_b_o, 0);
        pin_in[3] = 1'b0;
        count_high(8, 1'b1, hits);
        check("R6 falling edge ignored", hits, 0);
        mask_b = '0;
    endtask

    task automatic t_fall();
        int hits;
        edge_cfg[4] = 1'b1;
        polar_cfg[4] = 1'b1;
        mask_b = 16'h0010;
        step(1);
        pin_in[4] = 1'b1;
        count_high(8, 1'b1, hits);
        check("R7 rising edge ignored", hits, 0);
        pin_in[4] = 1'b0;
        count_high(8, 1'b1, hits);
        check("R7 falling edge one pulse", hits, 1);
        mask_b = '0;
    endtask

    task automatic t_both();
        int hits;
        edge_cfg[5] = 1'b1;
        both_cfg[5] = 1'b1;
        mask_a = 16'h0020;
        step(1);
        pin_in[5] = 1'b1;
        count_high(8, 1'b0, hits);
        check("R5 both-edge rise one pulse", hits, 1);
        pin_in[5] = 1'b0;
        count_high(8, 1'b0, hits);
        check("R5 both-edge fall one pulse", hits, 1);
        mask_a = '0;
    endtask

    task automatic t_mask();
        pin_in[6] = 1'b1;
        step(5);
        check("R9 unmasked level gives no irq_a", irq_a_o, 0);
        check("R9 unmasked level gives no irq_b", irq_b_o, 0);
        mask_b = 16'h0040;
        step(1);
        check("R10 mask_b set seen next edge", irq_b_o, 1);
        check("R9 irq_a unaffected by mask_b", irq_a_o, 0);
        mask_b = '0;
        step(1);
        check("R10 mask_b clear seen next edge", irq_b_o, 0);
        pin_in[6] = 1'b0;
        step(4);
    endtask

    task automatic t_coincide();
        edge_cfg[7] = 1'b1;
        step(1);
        pin_in[7] = 1'b1;
        step(3);
        mask_a = 16'h0080;
        step(1);
        check("R8 pulse meets mask set", irq_a_o, 1);
        step(1);
        check("R8 pulse gone after one cycle", irq_a_o, 0);
        mask_a = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_level_high();
        t_level_low();
        t_ignore();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_coincide();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule